// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a small fully associative translation cache for 8 KiB pages. Each slot holds virtual page bits 63..13, a 13-bit context number, a physical page number (physical bits 40..13) and a few flag bits taken from a 64-bit mapping word. A lookup presents a virtual address and the running context. One cycle later the block reports either a hit, with the translated physical address and the access attributes, or a one-cycle miss that carries the address and context that failed. A miss handler uses that report to find the mapping and insert it through the fill port.

Replacement uses true least-recently-used order kept as per-slot ages. Slots can be pinned through a lock flag so that the miss handler's own mappings are never evicted. Slots marked global answer to every context. A flush port removes all ordinary mappings of one context in a single command. The flush is run by a small sweep state machine with states `ST_IDLE`, `ST_SWEEP` and `ST_DONE`. The transitions are: IDLE to SWEEP when a flush is accepted (the slot index starts at 0). SWEEP stays in SWEEP while the index has not reached the last slot, and advances the index by one each cycle. SWEEP goes to DONE after the last slot is handled. DONE goes back to IDLE unconditionally.

Top module: `ctx_tlb`

## Requirements
- R1: A slot matches a lookup when its stored virtual page (address bits 63..13) equals that of the lookup address and either its context equals the lookup context or its global flag (mapping bit 0) is set; a global slot matches any context.
- R2: A slot whose stored valid flag (mapping bit 63) is clear never produces a hit, even if its page and context match.
- R3: One cycle after an accepted lookup that matches, `lk_hit` is high for one cycle, `lk_pa` equals mapping bits 40..13 followed by lookup address bits 12..0, and `lk_attr` is {side-effect (bit 3), privileged (bit 2), writable (bit 1)} of the mapping.
- R4: One cycle after an accepted lookup with no match, `lk_miss` is high for one cycle and `miss_va`/`miss_ctx` hold the lookup address and context; `lk_hit` and `lk_miss` are never high together, and neither is high unless a lookup was accepted in the cycle before.
- R5: An accepted fill writes the lowest-numbered invalid slot if there is one, otherwise the unlocked valid slot that was used least recently; a hit and a fill both make that slot the most recently used; `fill_done` pulses one cycle after the fill is written.
- R6: A valid slot whose lock flag (mapping bit 6) is set is never chosen to be overwritten by a fill.
- R7: When every slot is valid and locked, a fill writes nothing, `fill_err` pulses for one cycle and `fill_done` stays low.
- R8: A flush of context C invalidates every valid slot whose context is C unless that slot is global or locked; slots of other contexts are untouched; `flush_done` is high for exactly one cycle when the sweep ends.
- R9: While `busy` is high (from the cycle after a flush is accepted until `flush_done` has been shown), lookups and fills are ignored; when idle, a flush request wins over a fill, and a fill wins over a lookup presented in the same cycle (the lookup is dropped).
- R10: After reset every slot is invalid and `lk_hit`, `lk_miss`, `fill_done`, `fill_err`, `flush_done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_ctx | input | 13 | Lookup context |
| lk_hit | output | 1 | Lookup matched (one cycle after request) |
| lk_miss | output | 1 | Lookup found no match (one cycle after request) |
| lk_pa | output | 41 | Translated physical address, valid with `lk_hit` |
| lk_attr | output | 3 | {side-effect, privileged, writable}, valid with `lk_hit` |
| miss_va | output | 64 | Address of the lookup that missed |
| miss_ctx | output | 13 | Context of the lookup that missed |
| fill_valid | input | 1 | Fill request |
| fill_va | input | 64 | Virtual address of the new mapping (bits 63..13 used) |
| fill_ctx | input | 13 | Context of the new mapping |
| fill_data | input | 64 | Mapping word: valid 63, physical page 40..13, lock 6, side-effect 3, privileged 2, writable 1, global 0 |
| fill_done | output | 1 | Fill written |
| fill_err | output | 1 | Fill refused, all slots locked |
| flush_valid | input | 1 | Context flush request |
| flush_ctx | input | 13 | Context to flush |
| flush_done | output | 1 | Flush sweep finished |
| busy | output | 1 | Flush sweep in progress, requests ignored |

## Verification
Lookup and fill results are registered once, so `lk_hit`, `lk_miss`, `lk_pa`, `lk_attr`, `miss_va`, `miss_ctx`, `fill_done` and `fill_err` are due on the first rising edge after the edge that accepted the request. The bench drives every request on a falling edge, removes it on the next falling edge and reads the results at that same falling edge, half a cycle after they settle. A flush keeps `busy` high for one cycle per slot plus one cycle in DONE. The bench waits, one falling edge at a time, until `flush_done` is seen, then lets one more edge pass so the machine is idle again. A lookup placed inside the sweep window is checked for producing neither a hit nor a miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Bit positions inside the 64-bit mapping word
    localparam int MAP_W     = 64;
    localparam int MAP_VALID = 63;
    localparam int MAP_LOCK  = 6;
    localparam int MAP_SIDE  = 3;
    localparam int MAP_PRIV  = 2;
    localparam int MAP_WR    = 1;
    localparam int MAP_GLOB  = 0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWEEP = 2'd1,
        ST_DONE  = 2'd2
    } sweep_state_t;

    typedef struct packed {
        logic side;
        logic priv;
        logic wr;
    } page_attr_t;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N     = 8,
    parameter int VPN_W = 51,
    parameter int CTX_W = 13,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0][VPN_W-1:0] slot_vpn,
    input  logic [N-1:0][CTX_W-1:0] slot_ctx,
    input  logic [N-1:0]            slot_valid,
    input  logic [N-1:0]            slot_glob,
    input  logic [VPN_W-1:0]        req_vpn,
    input  logic [CTX_W-1:0]        req_ctx,
    output logic                    any_hit,
    output logic [IDX_W-1:0]        hit_idx
);

    logic [N-1:0] hit_vec;

    // One comparator per slot
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic page_eq;
        logic ctx_ok;
        assign page_eq    = (slot_vpn[g] == req_vpn);
        assign ctx_ok     = slot_glob[g] || (slot_ctx[g] == req_ctx);
        assign hit_vec[g] = slot_valid[g] && page_eq && ctx_ok;
    end

    // Lowest index wins if several slots match
    always_comb begin
        any_hit = 1'b0;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_age.sv
module tlb_age #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [N-1:0]     slot_valid,
    input  logic [N-1:0]     slot_lock,
    output logic             victim_ok,
    output logic [IDX_W-1:0] victim_idx
);

    // age 0 = most recently used, N-1 = least recently used
    logic [N-1:0][IDX_W-1:0] age_q;
    logic [N-1:0][IDX_W-1:0] age_d;

    always_comb begin
        age_d = age_q;
        if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    age_d[i] = '0;
                end else if (age_q[i] < age_q[touch_idx]) begin
                    age_d[i] = age_q[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                age_q[i] <= IDX_W'(i);
            end
        end else begin
            age_q <= age_d;
        end
    end

    // Victim: first free slot, else oldest slot that is not pinned
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic             cand_found;
    logic [IDX_W-1:0] cand_idx;
    logic [IDX_W-1:0] cand_age;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!slot_valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        cand_found = 1'b0;
        cand_idx   = '0;
        cand_age   = '0;
        for (int i = 0; i < N; i++) begin
            if (slot_valid[i] && !slot_lock[i] &&
                (!cand_found || age_q[i] > cand_age)) begin
                cand_found = 1'b1;
                cand_idx   = IDX_W'(i);
                cand_age   = age_q[i];
            end
        end
    end

    assign victim_ok  = free_found || cand_found;
    assign victim_idx = free_found ? free_idx : cand_idx;

endmodule

// File: rtl/tlb_fsm.sv
module tlb_fsm
    import tlb_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             sweep_en,
    output logic [IDX_W-1:0] sweep_idx,
    output logic             busy,
    output logic             sweep_done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    sweep_state_t     state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SWEEP;
                    idx_d   = '0;
                end
            end
            ST_SWEEP: begin
                if (idx_q == LAST) begin
                    state_d = ST_DONE;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Outputs
    always_comb begin
        sweep_en   = 1'b0;
        busy       = 1'b0;
        sweep_done = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SWEEP: begin
                sweep_en = 1'b1;
                busy     = 1'b1;
            end
            ST_DONE: begin
                busy       = 1'b1;
                sweep_done = 1'b1;
            end
            default:  ;
        endcase
    end

    assign sweep_idx = idx_q;

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 64,
    parameter int PAGE_W  = 13,
    parameter int CTX_W   = 13,
    parameter int PA_W    = 41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [CTX_W-1:0]  lk_ctx,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PA_W-1:0]   lk_pa,
    output logic [2:0]        lk_attr,
    output logic [VA_W-1:0]   miss_va,
    output logic [CTX_W-1:0]  miss_ctx,
    input  logic              fill_valid,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [CTX_W-1:0]  fill_ctx,
    input  logic [MAP_W-1:0]  fill_data,
    output logic              fill_done,
    output logic              fill_err,
    input  logic              flush_valid,
    input  logic [CTX_W-1:0]  flush_ctx,
    output logic              flush_done,
    output logic              busy
);

    localparam int VPN_W = VA_W - PAGE_W;
    localparam int PPN_W = PA_W - PAGE_W;
    localparam int IDX_W = $clog2(ENTRIES);

    // Slot storage
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][CTX_W-1:0] ctx_q;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
    page_attr_t [ENTRIES-1:0]      attr_q;
    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0]            lock_q;
    logic [ENTRIES-1:0]            glob_q;
    logic [CTX_W-1:0]              flush_ctx_q;

    // Mapping bits this block does not use
    logic unused_map_bits;
    assign unused_map_bits = ^{fill_data[MAP_VALID-1:PA_W], fill_data[PAGE_W-1:MAP_LOCK+1],
                               fill_data[MAP_LOCK-1:MAP_SIDE+1], fill_va[PAGE_W-1:0]};

    // Sweep controller
    logic             sweep_en;
    logic [IDX_W-1:0] sweep_idx;

    tlb_fsm #(.N(ENTRIES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (flush_valid),
        .sweep_en   (sweep_en),
        .sweep_idx  (sweep_idx),
        .busy       (busy),
        .sweep_done (flush_done)
    );

    // Request arbitration: flush > fill > lookup, only when idle
    logic do_flush, do_fill, do_look;
    assign do_flush = !busy && flush_valid;
    assign do_fill  = !busy && !flush_valid && fill_valid;
    assign do_look  = !busy && !flush_valid && !fill_valid && lk_valid;

    // Associative search
    logic             any_hit;
    logic [IDX_W-1:0] hit_idx;

    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_match (
        .slot_vpn   (vpn_q),
        .slot_ctx   (ctx_q),
        .slot_valid (valid_q),
        .slot_glob  (glob_q),
        .req_vpn    (lk_va[VA_W-1:PAGE_W]),
        .req_ctx    (lk_ctx),
        .any_hit    (any_hit),
        .hit_idx    (hit_idx)
    );

    // Recency and victim choice
    logic             victim_ok;
    logic [IDX_W-1:0] victim_idx;
    logic             fill_ok;
    logic             touch_en;
    logic [IDX_W-1:0] touch_idx;

    assign fill_ok   = do_fill && victim_ok;
    assign touch_en  = fill_ok || (do_look && any_hit);
    assign touch_idx = fill_ok ? victim_idx : hit_idx;

    tlb_age #(.N(ENTRIES)) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .slot_valid (valid_q),
        .slot_lock  (lock_q),
        .victim_ok  (victim_ok),
        .victim_idx (victim_idx)
    );

    // Slot writes: fill in idle, invalidation during sweep
    logic sweep_kill;
    assign sweep_kill = sweep_en && valid_q[sweep_idx] && !lock_q[sweep_idx] &&
                        !glob_q[sweep_idx] && (ctx_q[sweep_idx] == flush_ctx_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpn_q   <= '0;
            ctx_q   <= '0;
            ppn_q   <= '0;
            attr_q  <= '0;
            valid_q <= '0;
            lock_q  <= '0;
            glob_q  <= '0;
        end else begin
            if (fill_ok) begin
                vpn_q[victim_idx]   <= fill_va[VA_W-1:PAGE_W];
                ctx_q[victim_idx]   <= fill_ctx;
                ppn_q[victim_idx]   <= fill_data[PA_W-1:PAGE_W];
                attr_q[victim_idx]  <= '{side: fill_data[MAP_SIDE],
                                         priv: fill_data[MAP_PRIV],
                                         wr:   fill_data[MAP_WR]};
                valid_q[victim_idx] <= fill_data[MAP_VALID];
                lock_q[victim_idx]  <= fill_data[MAP_LOCK];
                glob_q[victim_idx]  <= fill_data[MAP_GLOB];
            end
            if (sweep_kill) begin
                valid_q[sweep_idx] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flush_ctx_q <= '0;
        end else if (do_flush) begin
            flush_ctx_q <= flush_ctx;
        end
    end

    // Registered responses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_hit    <= 1'b0;
            lk_miss   <= 1'b0;
            lk_pa     <= '0;
            lk_attr   <= '0;
            miss_va   <= '0;
            miss_ctx  <= '0;
            fill_done <= 1'b0;
            fill_err  <= 1'b0;
        end else begin
            lk_hit    <= do_look && any_hit;
            lk_miss   <= do_look && !any_hit;
            fill_done <= fill_ok;
            fill_err  <= do_fill && !victim_ok;
            if (do_look && any_hit) begin
                lk_pa   <= {ppn_q[hit_idx], lk_va[PAGE_W-1:0]};
                lk_attr <= attr_q[hit_idx];
            end else begin
                lk_pa   <= '0;
                lk_attr <= '0;
            end
            if (do_look && !any_hit) begin
                miss_va  <= lk_va;
                miss_ctx <= lk_ctx;
            end
        end
    end

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             fill_done,
    input logic             fill_err,
    input logic             flush_done,
    input logic             busy,
    input logic             fill_ok,
    input logic [IDX_W-1:0] victim_idx,
    input logic [N-1:0]     valid_vec,
    input logic [N-1:0]     lock_vec
);

    // R4: hit and miss exclusive
    assert_hit_miss_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    // R4: a response needs a lookup accepted one cycle earlier
    assert_resp_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit || lk_miss) |-> $past(lk_valid && !busy));

    // R6: the chosen slot is never a pinned valid slot
    assert_no_locked_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ok |-> !(valid_vec[victim_idx] && lock_vec[victim_idx]));

    // R7: refusal only when everything was pinned
    assert_refuse_all_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_err |-> ($past(&(valid_vec & lock_vec)) && !fill_done));

    // R8: done lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);

    // R9: no slot becomes valid while sweeping
    assert_no_fill_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> ($countones(valid_vec) <= $countones($past(valid_vec))));

endmodule

bind ctx_tlb tlb_chk #(.N(ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_hit     (lk_hit),
    .lk_miss    (lk_miss),
    .fill_done  (fill_done),
    .fill_err   (fill_err),
    .flush_done (flush_done),
    .busy       (busy),
    .fill_ok    (fill_ok),
    .victim_idx (victim_idx),
    .valid_vec  (valid_q),
    .lock_vec   (lock_q)
);

// File: tb/ctx_tlb_test.sv
module ctx_tlb_test;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_va = '0;
    logic [12:0] lk_ctx = '0;
    logic        lk_hit, lk_miss;
    logic [40:0] lk_pa;
    logic [2:0]  lk_attr;
    logic [63:0] miss_va;
    logic [12:0] miss_ctx;
    logic        fill_valid = 1'b0;
    logic [63:0] fill_va = '0;
    logic [12:0] fill_ctx = '0;
    logic [63:0] fill_data = '0;
    logic        fill_done, fill_err;
    logic        flush_valid = 1'b0;
    logic [12:0] flush_ctx = '0;
    logic        flush_done, busy;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ctx_tlb #(.ENTRIES(N)) uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_ctx(lk_ctx),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .lk_attr(lk_attr),
        .miss_va(miss_va), .miss_ctx(miss_ctx),
        .fill_valid(fill_valid), .fill_va(fill_va), .fill_ctx(fill_ctx),
        .fill_data(fill_data), .fill_done(fill_done), .fill_err(fill_err),
        .flush_valid(flush_valid), .flush_ctx(flush_ctx),
        .flush_done(flush_done), .busy(busy)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Mapping word: valid 63, ppn 40..13, lock 6, attr 3..1, global 0
    function automatic logic [63:0] mk(input logic [27:0] ppn, input logic lock,
                                       input logic glob, input logic [2:0] attr);
        return {1'b1, 22'b0, ppn, 6'b0, lock, 2'b0, attr, glob};
    endfunction

    function automatic logic [63:0] va(input logic [50:0] vpn, input logic [12:0] off);
        return {vpn, off};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic lookup(input logic [63:0] a, input logic [12:0] c);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = a; lk_ctx = c;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [63:0] a, input logic [12:0] c, input logic [63:0] d);
        @(negedge clk);
        fill_valid = 1'b1; fill_va = a; fill_ctx = c; fill_data = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic exp_hit(input string tag, input logic [63:0] a, input logic [12:0] c,
                           input logic [63:0] d);
        lookup(a, c);
        chk({tag, " hit"}, lk_hit, 1'b1);
        chk({tag, " pa"}, lk_pa, {d[40:13], a[12:0]});
        chk({tag, " attr"}, lk_attr, d[3:1]);
    endtask

    task automatic exp_miss(input string tag, input logic [63:0] a, input logic [12:0] c);
        lookup(a, c);
        chk({tag, " miss"}, {lk_hit, lk_miss}, 2'b01);
        chk({tag, " miss_va"}, miss_va, a);
        chk({tag, " miss_ctx"}, miss_ctx, c);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 outputs in reset", {lk_hit, lk_miss, fill_done, fill_err, flush_done, busy}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        exp_miss("R10 empty after reset", va(51'h1, 13'h0), 13'd0);
    endtask

    task automatic t_translate();
        logic [63:0] d = mk(28'h0ABCDE1, 1'b0, 1'b0, 3'b101);
        do_reset();
        fill(va(51'h123, 13'h0), 13'd3, d);
        chk("R5 fill_done", {fill_done, fill_err}, 2'b10);
        exp_hit("R3 translate", va(51'h123, 13'h1ABC), 13'd3, d);
        exp_hit("R3 translate attr2", va(51'h123, 13'h0007), 13'd3, d);
    endtask

    task automatic t_context();
        logic [63:0] dn = mk(28'h11, 1'b0, 1'b0, 3'b010);
        logic [63:0] dg = mk(28'h22, 1'b0, 1'b1, 3'b001);
        do_reset();
        fill(va(51'hA0, 0), 13'd3, dn);
        fill(va(51'hB0, 0), 13'd3, dg);
        exp_miss("R1 wrong context", va(51'hA0, 13'h55), 13'd4);
        exp_hit("R1 right context", va(51'hA0, 13'h55), 13'd3, dn);
        exp_hit("R1 global any context", va(51'hB0, 13'h10), 13'h1FFF, dg);
        exp_miss("R4 unknown page", va(51'hC0, 13'h1), 13'd3);
    endtask

    task automatic t_valid();
        logic [63:0] d = mk(28'h33, 1'b0, 1'b0, 3'b000);
        do_reset();
        d[63] = 1'b0;
        fill(va(51'h77, 0), 13'd1, d);
        exp_miss("R2 invalid mapping", va(51'h77, 13'h2), 13'd1);
    endtask

    task automatic t_lru();
        do_reset();
        fill(va(51'h1, 0), 13'd0, mk(28'h1, 0, 0, 0));
        fill(va(51'h2, 0), 13'd0, mk(28'h2, 0, 0, 0));
        fill(va(51'h3, 0), 13'd0, mk(28'h3, 0, 0, 0));
        fill(va(51'h4, 0), 13'd0, mk(28'h4, 0, 0, 0));
        exp_hit("R5 touch first", va(51'h1, 0), 13'd0, mk(28'h1, 0, 0, 0));
        fill(va(51'h5, 0), 13'd0, mk(28'h5, 0, 0, 0));
        exp_miss("R5 oldest evicted", va(51'h2, 0), 13'd0);
        exp_hit("R5 new present", va(51'h5, 0), 13'd0, mk(28'h5, 0, 0, 0));
        exp_hit("R5 touched kept", va(51'h1, 0), 13'd0, mk(28'h1, 0, 0, 0));
        exp_hit("R5 third kept", va(51'h3, 0), 13'd0, mk(28'h3, 0, 0, 0));
    endtask

    task automatic t_lock();
        do_reset();
        fill(va(51'h10, 0), 13'd0, mk(28'h10, 1, 0, 0));
        fill(va(51'h11, 0), 13'd0, mk(28'h11, 0, 0, 0));
        fill(va(51'h12, 0), 13'd0, mk(28'h12, 0, 0, 0));
        fill(va(51'h13, 0), 13'd0, mk(28'h13, 0, 0, 0));
        fill(va(51'h14, 0), 13'd0, mk(28'h14, 0, 0, 0));
        exp_hit("R6 locked oldest kept", va(51'h10, 0), 13'd0, mk(28'h10, 1, 0, 0));
        exp_miss("R6 oldest unlocked evicted", va(51'h11, 0), 13'd0);
        exp_hit("R6 new present", va(51'h14, 0), 13'd0, mk(28'h14, 0, 0, 0));
    endtask

    task automatic t_all_locked();
        do_reset();
        for (int i = 0; i < N; i++) begin
            fill(va(51'h20 + 51'(i), 0), 13'd0, mk(28'h20 + 28'(i), 1, 0, 0));
        end
        fill(va(51'h30, 0), 13'd0, mk(28'h30, 0, 0, 0));
        chk("R7 refused", {fill_done, fill_err}, 2'b01);
        @(negedge clk);
        chk("R7 err one cycle", fill_err, 1'b0);
        exp_miss("R7 nothing written", va(51'h30, 0), 13'd0);
        exp_hit("R7 locked intact", va(51'h20, 0), 13'd0, mk(28'h20, 1, 0, 0));
    endtask

    task automatic t_flush();
        int waited = 0;
        do_reset();
        fill(va(51'h40, 0), 13'd5, mk(28'h40, 0, 0, 0));
        fill(va(51'h41, 0), 13'd5, mk(28'h41, 0, 1, 0));
        fill(va(51'h42, 0), 13'd5, mk(28'h42, 1, 0, 0));
        fill(va(51'h43, 0), 13'd7, mk(28'h43, 0, 0, 0));
        @(negedge clk);
        flush_valid = 1'b1; flush_ctx = 13'd5;
        @(negedge clk);
        flush_valid = 1'b0;
        chk("R9 busy during sweep", busy, 1'b1);
        lookup(va(51'h43, 0), 13'd7);
        chk("R9 lookup ignored while busy", {lk_hit, lk_miss}, 2'b00);
        while (!flush_done && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        chk("R8 flush_done seen", flush_done, 1'b1);
        @(negedge clk);
        chk("R8 done one cycle, idle", {flush_done, busy}, 2'b00);
        exp_miss("R8 plain entry removed", va(51'h40, 0), 13'd5);
        exp_hit("R8 global kept", va(51'h41, 0), 13'd5, mk(28'h41, 0, 1, 0));
        exp_hit("R8 locked kept", va(51'h42, 0), 13'd5, mk(28'h42, 1, 0, 0));
        exp_hit("R8 other context kept", va(51'h43, 0), 13'd7, mk(28'h43, 0, 0, 0));
    endtask

    task automatic t_priority();
        do_reset();
        @(negedge clk);
        fill_valid = 1'b1; fill_va = va(51'h50, 0); fill_ctx = 13'd2;
        fill_data = mk(28'h50, 0, 0, 3'b111);
        lk_valid = 1'b1; lk_va = va(51'h99, 0); lk_ctx = 13'd2;
        @(negedge clk);
        fill_valid = 1'b0; lk_valid = 1'b0;
        chk("R9 fill wins", fill_done, 1'b1);
        chk("R9 lookup dropped", {lk_hit, lk_miss}, 2'b00);
        exp_hit("R9 filled entry", va(51'h50, 13'h3), 13'd2, mk(28'h50, 0, 0, 3'b111));
    endtask

    initial begin
        t_reset();
        t_translate();
        t_context();
        t_valid();
        t_lru();
        t_lock();
        t_all_locked();
        t_flush();
        t_priority();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule